// File: doc/BRIEF.md
# Serial Port Interrupt Flag Unit

This block holds the eight-bit interrupt flag register of a serial port and drives the port's single interrupt line. It sits at one offset of a small register bus. The transmitter, the receiver, the error checker, the clear-to-send pin and the sleep controller report events and buffer states on plain inputs. The shift registers, baud generation and sleep logic are not part of the block. Each flag follows its own rule. Some flags latch an event until software writes a one to them. Two flags mirror the state of a buffer. Two flags latch and are also cleared automatically by a data event.

The block contains a break-and-sync tracker. On each bit-period strobe it samples the receive line and counts consecutive low samples. A run of at least eleven low samples arms the tracker. If the next received byte is the sync pattern 0x55, the break flag is raised. The clear-to-send input is asynchronous, so it passes through a two-flop synchroniser before its edges are detected. The interrupt output is the OR of all flags after masking with an enable vector.

Top module: `sport_flag_unit`

## Requirements
- R1: After reset every stored flag is 0. A bus read at offset 0x0D returns the register, with ERROR in bit 7, CTSIC in bit 6, RXBRK in bit 4, RXS in bit 3, RXC in bit 2, TXC in bit 1 and DRE in bit 0. Bit 5 always reads 0. A read at any other offset returns 0.
- R2: A bus write at offset 0x0D clears each latched flag whose data bit is 1. A data bit of 0, or a write to another offset, has no effect.
- R3: ERROR sets in the cycle after any of the parity, frame, sync, collision or overflow error inputs is high. Only a write-one-to-clear clears it.
- R4: CTSIC sets on either a rising or a falling change of the CTS input. It becomes visible on the third clock edge after the change is applied, and is cleared by write-one-to-clear.
- R5: With frame mode 2 (LIN client) or 3 (auto-baud), at least 11 consecutive low receive samples on bit-tick strobes arm the tracker. A following received byte of 0x55 then sets RXBRK. A high sample resets the low-sample count, so shorter runs never arm.
- R6: RXBRK never sets in frame mode 0 (asynchronous) or mode 1 (SPI host). It also does not set when the first byte after a break differs from 0x55; that byte disarms the tracker.
- R7: RXBRK clears on the next received byte that does not itself complete a sync. It is also cleared by write-one-to-clear.
- R8: RXS sets when start-of-frame detection is enabled, standby is active and a valid start bit is reported, in any frame mode except 1 (SPI host). It is cleared by write-one-to-clear.
- R9: RXC reads the receive-buffer-unread input directly. Writes do not affect it.
- R10: TXC sets when a frame finishes shifting while the transmit buffer is empty. A transmit-data write or a write-one-to-clear clears it.
- R11: DRE reads the transmit-buffer-empty input directly. Writes do not affect it.
- R12: When a hardware set and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R13: The interrupt output is high exactly when some register bit is 1 and its enable-mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register bus address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Write data, one bit per flag to clear |
| bus_rdata | output | 8 | Read data, combinational from the address |
| err_parity | input | 1 | Parity error event |
| err_frame | input | 1 | Frame error event |
| err_sync | input | 1 | Inconsistent sync field error event |
| err_collision | input | 1 | Transmit collision event |
| err_overflow | input | 1 | Receive buffer overflow event |
| cts_pin | input | 1 | Asynchronous clear-to-send pin |
| frame_mode | input | 2 | 0 async, 1 SPI host, 2 LIN client, 3 auto-baud |
| sof_enable | input | 1 | Start-of-frame detection enabled |
| standby | input | 1 | Device is in standby sleep |
| rx_start_seen | input | 1 | Valid start bit detected |
| rx_line | input | 1 | Receive line level |
| bit_tick | input | 1 | One strobe per bit period |
| rx_byte_valid | input | 1 | A received byte is delivered |
| rx_byte | input | 8 | The received byte value |
| rx_buf_unread | input | 1 | Receive buffer holds unread data |
| tx_buf_empty | input | 1 | Transmit data buffer is empty |
| tx_frame_done | input | 1 | Shift register finished a frame |
| tx_data_write | input | 1 | Transmit data register written |
| irq_mask | input | 8 | Per-bit interrupt enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The latched flags change on the clock edge that follows the cycle of their cause. The bench therefore drives inputs just after a falling edge and advances its reference state at the next rising edge. It compares only at the falling edge after that. Read data, the two level flags and the interrupt output are combinational, and they are compared a short delay after the inputs change within the same cycle. A CTS change is due on the third rising edge, because of the two synchroniser flops and the edge flop. The directed test checks that the flag is still clear after two edges and set after the third. A break arms on the edge that takes the eleventh low sample. RXBRK shows after the edge of the byte that carries the sync pattern.

// File: rtl/sport_flag_pkg.sv
// Shared constants for the serial port interrupt flag unit.
// Assumes: register bit positions are fixed and decoded by software.
package sport_flag_pkg;

    typedef enum logic [1:0] {
        FM_ASYNC      = 2'd0,
        FM_SPI_HOST   = 2'd1,
        FM_LIN_CLIENT = 2'd2,
        FM_AUTOBAUD   = 2'd3
    } frame_mode_e;

    localparam int BIT_ERR  = 7;
    localparam int BIT_CTS  = 6;
    localparam int BIT_BRK  = 4;
    localparam int BIT_SOF  = 3;
    localparam int BIT_RXC  = 2;
    localparam int BIT_TXC  = 1;
    localparam int BIT_DRE  = 0;

    // Latched flags, in the order of the generate array in the top.
    localparam int NUM_LATCHED = 5;
    localparam int L_ERR = 0;
    localparam int L_CTS = 1;
    localparam int L_BRK = 2;
    localparam int L_SOF = 3;
    localparam int L_TXC = 4;

endpackage

// File: rtl/sticky_flag.sv
// One latched interrupt flag.
// A set input raises the flag and a clear input drops it; set has priority.
// Assumes: set and clear are already qualified by the caller.
module sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // Holds the flag, with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);                                        // R12
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);                           // R2

endmodule

// File: rtl/cts_edge_detect.sv
// Brings the asynchronous clear-to-send pin into the clock domain and
// flags a change of level in either direction.
// Assumes: the pin is held low while reset is applied.
module cts_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic change_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Shifts the pin through the synchroniser chain and keeps the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign change_o = sync_q[SYNC_STAGES-1] ^ last_q;

    AST_CHANGE_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        change_o |-> $past(sync_q[SYNC_STAGES-2]) != last_q);   // R4

endmodule

// File: rtl/break_sync_detect.sv
// Counts consecutive low receive samples, arms after a break of BRK_LEN
// bits and reports a hit when the next received byte equals SYNC_VAL.
// Assumes: rx_line is sampled only on bit_tick; enable reflects frame mode.
module break_sync_detect #(
    parameter int         BRK_LEN  = 11,
    parameter logic [7:0] SYNC_VAL = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       bit_tick_i,
    input  logic       rx_line_i,
    input  logic       byte_valid_i,
    input  logic [7:0] byte_i,
    output logic       sync_hit_o
);

    localparam int CW = $clog2(BRK_LEN + 1);

    logic [CW-1:0] low_cnt_q;
    logic          armed_q;
    logic          low_tick;

    assign low_tick = bit_tick_i && !rx_line_i;

    // Tracks the low-sample run length and the armed state.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            low_cnt_q <= '0;
            armed_q   <= 1'b0;
        end else begin
            if (bit_tick_i) begin
                if (rx_line_i)                       low_cnt_q <= '0;
                else if (low_cnt_q != CW'(BRK_LEN))  low_cnt_q <= low_cnt_q + 1'b1;
            end
            if (low_tick && low_cnt_q == CW'(BRK_LEN - 1)) armed_q <= 1'b1;
            else if (byte_valid_i)                         armed_q <= 1'b0;
        end
    end

    assign sync_hit_o = enable_i && armed_q && byte_valid_i && (byte_i == SYNC_VAL);

    AST_ARM_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_q) |-> $past(low_tick));                   // R5
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !armed_q);                               // R6

endmodule

// File: rtl/sport_flag_unit.sv
// Interrupt flag register of a serial port at one bus offset.
// Latched flags use write-one-to-clear; RXC and DRE mirror buffer levels;
// TXC and RXBRK also clear on data events. Drives a masked combined irq.
// Assumes: event inputs are single-cycle pulses in the clock domain,
// except cts_pin, which is asynchronous.
module sport_flag_unit
    import sport_flag_pkg::*;
#(
    parameter int         ADDR_W      = 4,
    parameter logic [3:0] FLAG_OFFSET = 4'hD,
    parameter int         BRK_LEN     = 11,
    parameter logic [7:0] SYNC_VAL    = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              err_parity,
    input  logic              err_frame,
    input  logic              err_sync,
    input  logic              err_collision,
    input  logic              err_overflow,
    input  logic              cts_pin,
    input  logic [1:0]        frame_mode,
    input  logic              sof_enable,
    input  logic              standby,
    input  logic              rx_start_seen,
    input  logic              rx_line,
    input  logic              bit_tick,
    input  logic              rx_byte_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_buf_unread,
    input  logic              tx_buf_empty,
    input  logic              tx_frame_done,
    input  logic              tx_data_write,
    input  logic [7:0]        irq_mask,
    output logic              irq
);

    frame_mode_e mode;
    logic        hit;
    logic [7:0]  w1c;
    logic        cts_change;
    logic        brk_enable;
    logic        sync_hit;
    logic [NUM_LATCHED-1:0] set_v, clr_v, q_v;
    logic [7:0]  flags;

    assign mode       = frame_mode_e'(frame_mode);
    assign hit        = (bus_addr == ADDR_W'(FLAG_OFFSET));
    assign w1c        = (bus_wr && hit) ? bus_wdata : 8'h00;
    assign brk_enable = (mode == FM_LIN_CLIENT) || (mode == FM_AUTOBAUD);

    cts_edge_detect #(.SYNC_STAGES(2)) u_cts (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (cts_pin),
        .change_o (cts_change)
    );

    break_sync_detect #(.BRK_LEN(BRK_LEN), .SYNC_VAL(SYNC_VAL)) u_brk (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (brk_enable),
        .bit_tick_i   (bit_tick),
        .rx_line_i    (rx_line),
        .byte_valid_i (rx_byte_valid),
        .byte_i       (rx_byte),
        .sync_hit_o   (sync_hit)
    );

    // Gathers the set and clear condition of every latched flag.
    always_comb begin
        set_v[L_ERR] = err_parity | err_frame | err_sync | err_collision | err_overflow;
        clr_v[L_ERR] = w1c[BIT_ERR];
        set_v[L_CTS] = cts_change;
        clr_v[L_CTS] = w1c[BIT_CTS];
        set_v[L_BRK] = sync_hit;
        clr_v[L_BRK] = w1c[BIT_BRK] | rx_byte_valid;
        set_v[L_SOF] = sof_enable && standby && rx_start_seen && (mode != FM_SPI_HOST);
        clr_v[L_SOF] = w1c[BIT_SOF];
        set_v[L_TXC] = tx_frame_done && tx_buf_empty;
        clr_v[L_TXC] = w1c[BIT_TXC] | tx_data_write;
    end

    for (genvar i = 0; i < NUM_LATCHED; i++) begin : g_flag
        sticky_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[i]),
            .clr_i (clr_v[i]),
            .q_o   (q_v[i])
        );
    end

    // Assembles the register image from latched flags and buffer levels.
    always_comb begin
        flags          = 8'h00;
        flags[BIT_ERR] = q_v[L_ERR];
        flags[BIT_CTS] = q_v[L_CTS];
        flags[BIT_BRK] = q_v[L_BRK];
        flags[BIT_SOF] = q_v[L_SOF];
        flags[BIT_RXC] = rx_buf_unread;
        flags[BIT_TXC] = q_v[L_TXC];
        flags[BIT_DRE] = tx_buf_empty;
    end

    assign bus_rdata = hit ? flags : 8'h00;
    assign irq       = |(flags & irq_mask);

    AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_parity || err_frame || err_sync || err_collision || err_overflow)
        |=> q_v[L_ERR]);                                       // R3
    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (q_v[L_ERR] && !(bus_wr && hit && bus_wdata[7])) |=> q_v[L_ERR]); // R3
    AST_SOF_NOT_SPI: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_mode == 2'd1 && !q_v[L_SOF]) |=> !q_v[L_SOF]); // R8
    AST_TXC_DATA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_data_write && !(tx_frame_done && tx_buf_empty)) |=> !q_v[L_TXC]); // R10
    AST_RSV_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[5] == 1'b0);                                 // R1

endmodule

// File: tb/tb_sport_flag_unit.sv
// Self-checking bench: directed corner cases plus seeded random stimulus
// compared against a reference model built from the requirements.
module tb_sport_flag_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       err_parity, err_frame, err_sync, err_collision, err_overflow;
    logic       cts_pin;
    logic [1:0] frame_mode;
    logic       sof_enable, standby, rx_start_seen;
    logic       rx_line, bit_tick, rx_byte_valid;
    logic [7:0] rx_byte;
    logic       rx_buf_unread, tx_buf_empty, tx_frame_done, tx_data_write;
    logic [7:0] irq_mask;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sport_flag_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_parity(err_parity), .err_frame(err_frame), .err_sync(err_sync),
        .err_collision(err_collision), .err_overflow(err_overflow),
        .cts_pin(cts_pin), .frame_mode(frame_mode), .sof_enable(sof_enable),
        .standby(standby), .rx_start_seen(rx_start_seen), .rx_line(rx_line),
        .bit_tick(bit_tick), .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
        .rx_buf_unread(rx_buf_unread), .tx_buf_empty(tx_buf_empty),
        .tx_frame_done(tx_frame_done), .tx_data_write(tx_data_write),
        .irq_mask(irq_mask), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bus_addr = 4'hD; bus_wr = 0; bus_wdata = 0;
        {err_parity, err_frame, err_sync, err_collision, err_overflow} = '0;
        frame_mode = 2'd0; sof_enable = 0; standby = 0; rx_start_seen = 0;
        rx_line = 1; bit_tick = 0; rx_byte_valid = 0; rx_byte = 0;
        tx_frame_done = 0; tx_data_write = 0;
    endtask

    // One clock: from a falling edge to the next falling edge.
    task automatic cycle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic pulse_clear(input logic [7:0] bits);
        bus_wr = 1; bus_wdata = bits; cycle(); bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic sample(input logic lvl);
        rx_line = lvl; bit_tick = 1; cycle(); bit_tick = 0; rx_line = 1;
    endtask

    task automatic low_run(input int n);
        for (int i = 0; i < n; i++) sample(1'b0);
        sample(1'b1);
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_byte_valid = 1; rx_byte = b; cycle(); rx_byte_valid = 0;
    endtask

    // Reference update of latched flags: set wins, clear otherwise.
    function automatic logic upd(input logic q, input logic s, input logic c);
        return s | (q & ~c);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic m_err, m_cts, m_brk, m_sof, m_txc;
        logic [7:0] exp;
        void'($urandom(32'h5EED_0D01));
        idle_inputs();
        cts_pin = 0; rx_buf_unread = 0; tx_buf_empty = 0; irq_mask = 8'h00;
        rst_n = 0;
        repeat (3) cycle();
        rst_n = 1;
        cycle();

        // R1: reset state, reserved bit, other offsets
        #1 check("R1 reset value", bus_rdata, 8'h00);
        rx_buf_unread = 1; tx_buf_empty = 1;
        bus_addr = 4'h3;
        #1 check("R1 other offset reads 0", bus_rdata, 8'h00);
        bus_addr = 4'hD;
        // R9 R11: level flags follow inputs, unaffected by writes
        pulse_clear(8'hFF);
        #1 check("R9 R11 level flags survive write", bus_rdata, 8'h05);
        rx_buf_unread = 0; tx_buf_empty = 0;
        #1 check("R9 R11 level flags follow inputs", bus_rdata, 8'h00);

        // R3: each error source sets ERROR; write 0 keeps it; write 1 clears
        for (int k = 0; k < 5; k++) begin
            {err_parity, err_frame, err_sync, err_collision, err_overflow} = 5'b1 << k;
            cycle();
            {err_parity, err_frame, err_sync, err_collision, err_overflow} = '0;
            #1 check("R3 error source sets ERROR", bus_rdata, 8'h80);
            pulse_clear(8'h7F);
            #1 check("R2 write of 0 to bit keeps ERROR", bus_rdata, 8'h80);
            bus_addr = 4'h2; pulse_clear(8'hFF); bus_addr = 4'hD;
            #1 check("R2 write at other offset ignored", bus_rdata, 8'h80);
            pulse_clear(8'h80);
            #1 check("R3 w1c clears ERROR", bus_rdata, 8'h00);
        end

        // R12: set and clear in the same cycle
        err_frame = 1; bus_wr = 1; bus_wdata = 8'h80; cycle();
        err_frame = 0; bus_wr = 0;
        #1 check("R12 set wins over w1c", bus_rdata, 8'h80);
        pulse_clear(8'h80);

        // R4: CTS rising then falling, due on the third edge
        cts_pin = 1; cycle(); cycle();
        #1 check("R4 CTSIC not before third edge", bus_rdata, 8'h00);
        cycle();
        #1 check("R4 CTSIC set on rising change", bus_rdata, 8'h40);
        pulse_clear(8'h40);
        #1 check("R4 CTSIC cleared", bus_rdata, 8'h00);
        cts_pin = 0; repeat (3) cycle();
        #1 check("R4 CTSIC set on falling change", bus_rdata, 8'h40);
        pulse_clear(8'h40);

        // R5: break length threshold and sync
        frame_mode = 2'd2;
        low_run(10); send_byte(8'h55);
        #1 check("R5 ten low bits do not arm", bus_rdata, 8'h00);
        for (int i = 0; i < 6; i++) sample(1'b0);
        sample(1'b1);
        for (int i = 0; i < 6; i++) sample(1'b0);
        sample(1'b1); send_byte(8'h55);
        #1 check("R5 high sample restarts count", bus_rdata, 8'h00);
        low_run(11); send_byte(8'h55);
        #1 check("R5 break and sync set RXBRK", bus_rdata, 8'h10);
        // R7: next byte clears it
        send_byte(8'h12);
        #1 check("R7 next byte clears RXBRK", bus_rdata, 8'h00);
        frame_mode = 2'd3;
        low_run(14); send_byte(8'h55);
        #1 check("R5 auto-baud mode sets RXBRK", bus_rdata, 8'h10);
        pulse_clear(8'h10);
        #1 check("R7 w1c clears RXBRK", bus_rdata, 8'h00);
        // R6: wrong sync, then a stray 0x55 without break
        low_run(11); send_byte(8'h33); send_byte(8'h55);
        #1 check("R6 wrong sync byte disarms", bus_rdata, 8'h00);
        frame_mode = 2'd0;
        low_run(11); send_byte(8'h55);
        #1 check("R6 async mode never sets RXBRK", bus_rdata, 8'h00);
        frame_mode = 2'd1;
        low_run(11); send_byte(8'h55);
        #1 check("R6 SPI host mode never sets RXBRK", bus_rdata, 8'h00);

        // R8: start-of-frame conditions
        sof_enable = 1; standby = 1; rx_start_seen = 1; cycle(); rx_start_seen = 0;
        #1 check("R8 RXS blocked in SPI host", bus_rdata, 8'h00);
        frame_mode = 2'd0; standby = 0; rx_start_seen = 1; cycle(); rx_start_seen = 0;
        #1 check("R8 RXS needs standby", bus_rdata, 8'h00);
        standby = 1; rx_start_seen = 1; cycle(); rx_start_seen = 0;
        #1 check("R8 RXS set", bus_rdata, 8'h08);
        pulse_clear(8'h08);
        #1 check("R8 RXS cleared by w1c", bus_rdata, 8'h00);
        sof_enable = 0; standby = 0;

        // R10: TXC set, needs empty buffer, data write clears
        tx_buf_empty = 0; tx_frame_done = 1; cycle(); tx_frame_done = 0;
        #1 check("R10 TXC needs empty buffer", bus_rdata, 8'h00);
        tx_buf_empty = 1; tx_frame_done = 1; cycle(); tx_frame_done = 0;
        #1 check("R10 TXC set", bus_rdata, 8'h03);
        // R13: masking
        irq_mask = 8'h02;
        #1 check("R13 irq with enabled TXC", {7'd0, irq}, 8'h01);
        irq_mask = 8'hFC;
        #1 check("R13 irq masked off", {7'd0, irq}, 8'h00);
        tx_data_write = 1; cycle(); tx_data_write = 0;
        #1 check("R10 data write clears TXC", bus_rdata, 8'h01);
        tx_buf_empty = 0;

        // Random phase against the reference model
        m_err = 0; m_cts = 0; m_brk = 0; m_sof = 0; m_txc = 0;
        frame_mode = 2'd0;
        for (int n = 0; n < 600; n++) begin
            logic ev_err, ev_sof, ev_txc;
            logic [7:0] wc;
            {err_parity, err_frame, err_sync, err_collision, err_overflow} =
                ($urandom_range(0, 5) == 0) ? 5'($urandom) : 5'd0;
            frame_mode    = 2'($urandom);
            sof_enable    = $urandom_range(0, 3) != 0;
            standby       = $urandom_range(0, 3) != 0;
            rx_start_seen = $urandom_range(0, 4) == 0;
            rx_buf_unread = 1'($urandom);
            tx_buf_empty  = 1'($urandom);
            tx_frame_done = $urandom_range(0, 3) == 0;
            tx_data_write = $urandom_range(0, 5) == 0;
            bus_addr      = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hD;
            bus_wr        = $urandom_range(0, 2) == 0;
            bus_wdata     = 8'($urandom);
            irq_mask      = 8'($urandom);
            #1;
            exp = {m_err, m_cts, 1'b0, m_brk, m_sof, rx_buf_unread, m_txc, tx_buf_empty};
            check("R1 R2 R3 R8 R9 R10 R11 R12 random read",
                  bus_rdata, (bus_addr == 4'hD) ? exp : 8'h00);
            check("R13 random irq", {7'd0, irq}, {7'd0, |(exp & irq_mask)});
            wc     = (bus_wr && bus_addr == 4'hD) ? bus_wdata : 8'h00;
            ev_err = err_parity | err_frame | err_sync | err_collision | err_overflow;
            ev_sof = sof_enable && standby && rx_start_seen && frame_mode != 2'd1;
            ev_txc = tx_frame_done && tx_buf_empty;
            m_err  = upd(m_err, ev_err, wc[7]);
            m_sof  = upd(m_sof, ev_sof, wc[3]);
            m_txc  = upd(m_txc, ev_txc, wc[1] | tx_data_write);
            m_cts  = upd(m_cts, 1'b0, wc[6]);
            m_brk  = upd(m_brk, 1'b0, wc[4]);
            cycle();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule